// File: doc/BRIEF.md
# Quick DMA Channel Trigger Controller

This block keeps the channel state for a bank of quick DMA channels. Each channel is bound to one entry of a parameter memory and to one word inside that entry. Software writes the binding, the channel enables and the clear bits through a single register write port. The same port also carries writes into the parameter memory. The memory itself lives elsewhere, and this block only watches the addresses. When a parameter write lands on the bound word of an enabled channel, the channel raises a transfer request. That request carries the channel number and the parameter entry number to the transfer engine over a valid/ready handshake.

The transfer engine returns a 6-bit completion code when it finishes. Each code sets one bit of a 64-bit pending vector. Software reads the vector in two 32-bit halves and clears bits by writing ones. A channel triggered again before its earlier request was taken records a missed event rather than queueing a second request. All registers read back through a combinational read port, and unused offsets read as zero.

Top module: `qdma_trig_ctrl`

## Requirements
- R1: After reset every channel binding, enable, request-pending and missed bit is zero, the completion vector is zero and req_valid is low.
- R2: A write to offset 0x200 + 4*c stores a binding for channel c: entry number from data bits [13:5] and trigger word from bits [4:2]. A read returns only those bits. A binding value of zero means the channel is unbound and never triggers.
- R3: Writing ones to 0x108C sets channel enables, and writing ones to 0x1088 clears them. The enable vector reads at 0x1084 in bits [7:0]. A disabled channel does not trigger.
- R4: A write to 0x4000 + 32*entry + 4*word that matches an enabled, bound channel sets its request-pending bit. req_valid is high from the next cycle, with req_chan naming the channel and req_set its entry. A write to another word of the same entry does not trigger.
- R5: A trigger on a channel whose request-pending bit is already set sets the channel's missed bit instead of queueing a second request. The missed vector reads at 0x310 in bits [7:0]. Writing ones to 0x314 clears missed bits.
- R6: When several channels have requests pending, the lowest-numbered one is presented. A cycle with req_valid and req_ready both high removes that channel's request from the next cycle.
- R7: Writing ones to 0x1094 withdraws the pending requests of the selected channels.
- R8: A cycle with cmp_valid high sets completion bit cmp_code. Codes 0..31 read at 0x1068 bit code. Codes 32..63 read at 0x106C bit code-32.
- R9: Writing ones to 0x1070 clears completion bits 0..31, and writing ones to 0x1074 clears bits 32..63. A completion arriving in the same cycle as a clear of the same bit leaves that bit set.
- R10: Offsets not listed above read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register or parameter write strobe |
| wr_addr | input | 16 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 16 | Byte offset of the combinational read |
| rd_data | output | 32 | Read data |
| req_valid | output | 1 | A transfer request is presented |
| req_ready | input | 1 | Transfer engine accepts the request |
| req_chan | output | 3 | Channel of the presented request |
| req_set | output | 9 | Parameter entry of the presented request |
| cmp_valid | input | 1 | Completion code strobe |
| cmp_code | input | 6 | Completion code |

## Verification
The bench builds the block with its defaults: eight channels and a 6-bit completion code. With these values every channel and every one of the 64 completion bits can be swept exhaustively. Each channel gets a binding computed from its number. The bench then checks a wrong-word write, a matching write, a repeated trigger and the acceptance for every channel in turn. It also covers priority among pending channels, withdrawal of requests, removal of a binding, and completion bits set in the same cycle as a clear.

// File: rtl/qdma_pkg.sv
package qdma_pkg;
  localparam int unsigned AW     = 16;
  localparam int unsigned DW     = 32;
  localparam int unsigned SET_W  = 9;
  localparam int unsigned WORD_W = 3;

  localparam logic [AW-1:0] OFF_MAP0     = 16'h0200;
  localparam logic [AW-1:0] OFF_MISS_RD  = 16'h0310;
  localparam logic [AW-1:0] OFF_MISS_CLR = 16'h0314;
  localparam logic [AW-1:0] OFF_PEND_LO  = 16'h1068;
  localparam logic [AW-1:0] OFF_PEND_HI  = 16'h106C;
  localparam logic [AW-1:0] OFF_PCLR_LO  = 16'h1070;
  localparam logic [AW-1:0] OFF_PCLR_HI  = 16'h1074;
  localparam logic [AW-1:0] OFF_EN_RD    = 16'h1084;
  localparam logic [AW-1:0] OFF_EN_CLR   = 16'h1088;
  localparam logic [AW-1:0] OFF_EN_SET   = 16'h108C;
  localparam logic [AW-1:0] OFF_SEC_CLR  = 16'h1094;

  typedef struct packed {
    logic [SET_W-1:0]  set;
    logic [WORD_W-1:0] word;
  } bind_t;

  // Byte offset of channel c's binding register
  function automatic logic [AW-1:0] bind_addr(int unsigned c);
    return OFF_MAP0 + AW'(c * 4);
  endfunction

  // Parameter memory window spans 0x4000..0x7FFF
  function automatic logic is_param(logic [AW-1:0] a);
    return a[AW-1:14] == 2'b01;
  endfunction

  function automatic logic [SET_W-1:0] param_set(logic [AW-1:0] a);
    return a[13:5];
  endfunction

  function automatic logic [WORD_W-1:0] param_word(logic [AW-1:0] a);
    return a[4:2];
  endfunction

  function automatic bind_t bind_unpack(logic [DW-1:0] d);
    bind_t b;
    b.set  = d[13:5];
    b.word = d[4:2];
    return b;
  endfunction

  function automatic logic [DW-1:0] bind_pack(bind_t b);
    return {{(DW-SET_W-WORD_W-2){1'b0}}, b.set, b.word, 2'b00};
  endfunction
endpackage

// File: rtl/qdma_chan_slot.sv
module qdma_chan_slot
  import qdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bind_we,
  input  bind_t            bind_wdata,
  input  logic             en_set,
  input  logic             en_clr,
  input  logic             sec_clr,
  input  logic             miss_clr,
  input  logic             pw_valid,
  input  logic [SET_W-1:0] pw_set,
  input  logic [WORD_W-1:0] pw_word,
  input  logic             grant,
  output bind_t            bind_q,
  output logic             en_q,
  output logic             sec_q,
  output logic             miss_q,
  output logic             trig
);
  logic bound;

  assign bound = (bind_q != '0);
  assign trig  = pw_valid && en_q && bound &&
                 (pw_set == bind_q.set) && (pw_word == bind_q.word);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bind_q <= '0;
      en_q   <= 1'b0;
      sec_q  <= 1'b0;
      miss_q <= 1'b0;
    end else begin
      if (bind_we) bind_q <= bind_wdata;

      if (en_set)      en_q <= 1'b1;
      else if (en_clr) en_q <= 1'b0;

      if (sec_clr)              sec_q <= 1'b0;
      else if (trig && !sec_q)  sec_q <= 1'b1;
      else if (grant)           sec_q <= 1'b0;

      if (miss_clr)             miss_q <= 1'b0;
      else if (trig && sec_q)   miss_q <= 1'b1;
    end
  end

  a_r4_trig_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !sec_q && !sec_clr) |=> sec_q);
  a_r5_miss_only_on_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miss_q) |-> $past(trig && sec_q));
  a_r3_disable_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (en_clr && !en_set) |=> !en_q);
endmodule

// File: rtl/qdma_req_pick.sv
module qdma_req_pick #(
  parameter int unsigned NUM_CH = 8,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req_vec,
  input  logic              ready,
  output logic              any,
  output logic [CH_W-1:0]   idx,
  output logic [NUM_CH-1:0] grant_vec
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req_vec[i]) begin
        any = 1'b1;
        idx = CH_W'(i);
      end
    end
  end

  assign grant_vec = (any && ready) ? (NUM_CH'(1) << idx) : '0;

  a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));
endmodule

// File: rtl/qdma_pend_bank.sv
module qdma_pend_bank #(
  parameter int unsigned CODE_W = 6,
  localparam int unsigned NBITS = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid,
  input  logic [CODE_W-1:0] cmp_code,
  input  logic [NBITS-1:0]  clr_mask,
  output logic [NBITS-1:0]  pend_q
);
  logic [NBITS-1:0] set_mask;

  assign set_mask = cmp_valid ? (NBITS'(1) << cmp_code) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_mask) | set_mask;
  end

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> pend_q[$past(cmp_code)]);
  a_r9_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_valid && clr_mask != '0) |=> ((pend_q & $past(clr_mask)) == '0));
endmodule

// File: rtl/qdma_trig_ctrl.sv
module qdma_trig_ctrl
  import qdma_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CODE_W = 6,
  localparam int unsigned CH_W  = $clog2(NUM_CH),
  localparam int unsigned NBITS = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [CH_W-1:0]   req_chan,
  output logic [SET_W-1:0]  req_set,
  input  logic              cmp_valid,
  input  logic [CODE_W-1:0] cmp_code
);
  bind_t             bind_arr [NUM_CH];
  logic [NUM_CH-1:0] en_vec, sec_vec, miss_vec, trig_vec, grant_vec;
  logic [NBITS-1:0]  pend_q, clr_mask;
  logic              pw_valid;
  logic [SET_W-1:0]  pw_set;
  logic [WORD_W-1:0] pw_word;
  logic              wr_en_set, wr_en_clr, wr_sec_clr, wr_miss_clr;

  assign pw_valid    = wr_en && is_param(wr_addr);
  assign pw_set      = param_set(wr_addr);
  assign pw_word     = param_word(wr_addr);
  assign wr_en_set   = wr_en && (wr_addr == OFF_EN_SET);
  assign wr_en_clr   = wr_en && (wr_addr == OFF_EN_CLR);
  assign wr_sec_clr  = wr_en && (wr_addr == OFF_SEC_CLR);
  assign wr_miss_clr = wr_en && (wr_addr == OFF_MISS_CLR);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic bind_hit;
    assign bind_hit = wr_en && (wr_addr == bind_addr(c));
    qdma_chan_slot u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .bind_we    (bind_hit),
      .bind_wdata (bind_unpack(wr_data)),
      .en_set     (wr_en_set && wr_data[c]),
      .en_clr     (wr_en_clr && wr_data[c]),
      .sec_clr    (wr_sec_clr && wr_data[c]),
      .miss_clr   (wr_miss_clr && wr_data[c]),
      .pw_valid   (pw_valid),
      .pw_set     (pw_set),
      .pw_word    (pw_word),
      .grant      (grant_vec[c]),
      .bind_q     (bind_arr[c]),
      .en_q       (en_vec[c]),
      .sec_q      (sec_vec[c]),
      .miss_q     (miss_vec[c]),
      .trig       (trig_vec[c])
    );
  end

  qdma_req_pick #(.NUM_CH(NUM_CH)) u_pick (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_vec   (sec_vec),
    .ready     (req_ready),
    .any       (req_valid),
    .idx       (req_chan),
    .grant_vec (grant_vec)
  );

  assign req_set = bind_arr[req_chan].set;

  // Completion clears: low half from one register, high half from the other
  always_comb begin
    clr_mask = '0;
    if (wr_en && wr_addr == OFF_PCLR_LO) clr_mask[DW-1:0]     = wr_data;
    if (wr_en && wr_addr == OFF_PCLR_HI) clr_mask[NBITS-1:DW] = wr_data;
  end

  qdma_pend_bank #(.CODE_W(CODE_W)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_valid (cmp_valid),
    .cmp_code  (cmp_code),
    .clr_mask  (clr_mask),
    .pend_q    (pend_q)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == OFF_EN_RD)        rd_data[NUM_CH-1:0] = en_vec;
    else if (rd_addr == OFF_MISS_RD) rd_data[NUM_CH-1:0] = miss_vec;
    else if (rd_addr == OFF_PEND_LO) rd_data = pend_q[DW-1:0];
    else if (rd_addr == OFF_PEND_HI) rd_data = pend_q[NBITS-1:DW];
    else begin
      for (int c = 0; c < NUM_CH; c++)
        if (rd_addr == bind_addr(c)) rd_data = bind_pack(bind_arr[c]);
    end
  end

  a_r6_accept_retires: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !sec_vec[$past(req_chan)]);
  a_r5_no_double_queue: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_vec[req_chan] && req_valid && !req_ready) |=> sec_vec[$past(req_chan)]);
endmodule

// File: tb/qdma_trig_ctrl_bench.sv
`timescale 1ns/1ps
module qdma_trig_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [15:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [2:0]  req_chan;
  logic [8:0]  req_set;
  logic        cmp_valid = 1'b0;
  logic [5:0]  cmp_code = '0;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  qdma_trig_ctrl u_qdma_trig_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_set(req_set), .cmp_valid(cmp_valid), .cmp_code(cmp_code)
  );

  function automatic int ent_of(int c);  return c * 37 + 5;     endfunction
  function automatic int word_of(int c); return (c * 3 + 1) % 8; endfunction
  function automatic logic [15:0] paddr(int e, int w);
    return 16'(16'h4000 + e * 32 + w * 4);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(logic [15:0] a, output logic [31:0] v);
    rd_addr = a;
    #0.1;
    v = rd_data;
  endtask

  task automatic accept();
    @(negedge clk); req_ready = 1'b1;
    @(negedge clk); req_ready = 1'b0;
  endtask

  task automatic complete(int code);
    @(negedge clk); cmp_valid = 1'b1; cmp_code = 6'(code);
    @(negedge clk); cmp_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] exp_miss;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 req_valid", {31'b0, req_valid}, 0);
    do_rd(16'h1084, v); check("R1 enable", v, 0);
    do_rd(16'h0310, v); check("R1 missed", v, 0);
    do_rd(16'h1068, v); check("R1 pend lo", v, 0);
    do_rd(16'h106C, v); check("R1 pend hi", v, 0);
    for (int c = 0; c < 8; c++) begin
      do_rd(16'(16'h0200 + c * 4), v); check("R1 binding", v, 0);
    end

    // R2 binding sweep, noise in unused bits must not read back
    for (int c = 0; c < 8; c++) begin
      do_wr(16'(16'h0200 + c * 4), 32'hFFFF_C003 | (ent_of(c) << 5) | (word_of(c) << 2));
      do_rd(16'(16'h0200 + c * 4), v);
      check("R2 binding readback", v, 32'((ent_of(c) << 5) | (word_of(c) << 2)));
    end

    // R10 unused offsets
    do_wr(16'h1080, 32'hFFFF_FFFF);
    do_rd(16'h1080, v); check("R10 unused read", v, 0);
    do_rd(16'h0220, v); check("R10 unused read past bindings", v, 0);
    do_rd(16'h1084, v); check("R10 write to unused left enables", v, 0);

    // R3 disabled channel does not trigger
    do_wr(paddr(ent_of(0), word_of(0)), 32'h1234);
    check("R3 disabled no request", {31'b0, req_valid}, 0);

    // R3 enable set / clear
    do_wr(16'h108C, 32'h0000_00FF);
    do_rd(16'h1084, v); check("R3 enable set", v, 32'hFF);
    do_wr(16'h1088, 32'h0000_0008);
    do_rd(16'h1084, v); check("R3 enable clear", v, 32'hF7);
    do_wr(paddr(ent_of(3), word_of(3)), 32'h1);
    check("R3 cleared channel silent", {31'b0, req_valid}, 0);
    do_wr(16'h108C, 32'h0000_0008);

    // R4 R5 R6 per-channel sweep
    exp_miss = 0;
    for (int c = 0; c < 8; c++) begin
      do_wr(paddr(ent_of(c), word_of(c) ^ 1), 32'h5);
      check("R4 wrong word silent", {31'b0, req_valid}, 0);
      do_wr(paddr(ent_of(c), word_of(c)), 32'h5);
      check("R4 request valid", {31'b0, req_valid}, 1);
      check("R4 request chan", {29'b0, req_chan}, 32'(c));
      check("R4 request entry", {23'b0, req_set}, 32'(ent_of(c)));
      do_wr(paddr(ent_of(c), word_of(c)), 32'h6);
      exp_miss |= 32'(1) << c;
      do_rd(16'h0310, v); check("R5 missed set", v, exp_miss);
      check("R5 still one request", {29'b0, req_chan}, 32'(c));
      accept();
      check("R6 accepted retires", {31'b0, req_valid}, 0);
    end
    do_wr(16'h0314, 32'h0000_005A);
    do_rd(16'h0310, v); check("R5 missed partial clear", v, 32'hA5);
    do_wr(16'h0314, 32'h0000_00FF);
    do_rd(16'h0310, v); check("R5 missed clear", v, 0);

    // R6 priority
    do_wr(paddr(ent_of(5), word_of(5)), 0);
    do_wr(paddr(ent_of(2), word_of(2)), 0);
    check("R6 lowest first", {29'b0, req_chan}, 2);
    accept();
    check("R6 next chan", {29'b0, req_chan}, 5);
    check("R6 next entry", {23'b0, req_set}, 32'(ent_of(5)));
    accept();
    check("R6 drained", {31'b0, req_valid}, 0);

    // R7 withdrawal
    do_wr(paddr(ent_of(4), word_of(4)), 0);
    check("R7 pre request", {31'b0, req_valid}, 1);
    do_wr(16'h1094, 32'h0000_0010);
    check("R7 withdrawn", {31'b0, req_valid}, 0);

    // R2 zero binding unbinds
    do_wr(16'h0204, 32'h0);
    do_wr(paddr(ent_of(1), word_of(1)), 0);
    check("R2 unbound old word silent", {31'b0, req_valid}, 0);
    do_wr(16'h4000, 0);
    check("R2 zero binding silent", {31'b0, req_valid}, 0);

    // R8 R9 full completion sweep
    for (int k = 0; k < 64; k++) begin
      complete(k);
      do_rd(16'h1068, v); check("R8 pend lo", v, (k < 32) ? (32'(1) << k) : 0);
      do_rd(16'h106C, v); check("R8 pend hi", v, (k >= 32) ? (32'(1) << (k - 32)) : 0);
      if (k < 32) do_wr(16'h1070, 32'(1) << k);
      else        do_wr(16'h1074, 32'(1) << (k - 32));
      do_rd(16'h1068, v); check("R9 cleared lo", v, 0);
      do_rd(16'h106C, v); check("R9 cleared hi", v, 0);
    end

    // R9 completion wins over simultaneous clear
    complete(9);
    complete(40);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_code = 6'd7;
    wr_en = 1'b1; wr_addr = 16'h1070; wr_data = 32'h0000_0280;
    @(negedge clk);
    cmp_valid = 1'b0; wr_en = 1'b0;
    do_rd(16'h1068, v); check("R9 set wins lo", v, 32'h0000_0080);
    do_rd(16'h106C, v); check("R9 other half kept", v, 32'h0000_0100);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule